// File: doc/BRIEF.md
# Cache snoop response controller

This block is the bus-side snoop logic of a processor whose data cache uses write-back. An external master first takes the bus by raising a hold request. Once the block has answered with a hold acknowledge, the master may present a snoop strobe together with an address and an invalidate flag. The invalidate flag is 0 when a read caused the snoop and 1 when a write caused it. The block looks the address up in a small direct-mapped tag store, with a valid bit and a dirty bit for each line. Two active-low indications, hit and hit-to-modified, are valid a fixed two clocks after the strobe is sampled.

When the snoop finds a dirty line, the block waits until the master has released the bus. It then writes the whole line back as a four-beat burst that starts at offset 0, and then updates the line's state. While a lookup or a write-back is in progress, further strobes are ignored. A preload port lets the surrounding test logic fill tags and line state. The data array is not modelled: each write-back beat carries its own beat address as a stand-in data word.

Top module: `snoop_ctrl`

## Requirements
- R1: `hold_ack` goes high one clock after `hold_req` is sampled high and low one clock after it is sampled low. While a write-back burst owns the bus, `hold_ack` stays low, and it may rise at the clock edge that completes the final beat.
- R2: A strobe is accepted only if `hold_ack` is high at the sampling edge. A strobe sampled while `hold_ack` is low is ignored: it causes no indication change, no burst and no change to line state.
- R3: For a strobe accepted at edge k, `hit_n` and `hitm_n` show that snoop's result from edge k+2. Before that edge they keep their earlier values.
- R4: The address fields are tag = bits 31:8, line index = bits 7:4 and offset = bits 3:0. A hit means the indexed line is valid and its tag matches. `hit_n` is 0 on a hit. `hitm_n` is 0 only on a hit to a dirty line, and stays 1 on a miss or on a hit to a clean line.
- R5: A write-back is four beats at addresses base, base+4, base+8 and base+12, where base is the snoop address with bits 3:0 cleared. `bus_data` equals `bus_addr` on each beat. `bus_last` is high during the fourth beat only.
- R6: `bus_ads` is high only in the first cycle of the burst, and `bus_wr` and `bus_mem` are high throughout the burst. A beat completes on each clock in which `bus_rdy_n` is sampled low. While `bus_rdy_n` is high, the address holds.
- R7: A write-back starts only after `hold_req` is low and `hold_ack` has dropped. `bus_ads` appears two clocks after `hold_req` is first sampled low.
- R8: After a dirty hit, `hit_n` and `hitm_n` stay low until the final beat completes, and both are high from that edge on.
- R9: While a lookup or a write-back is pending, strobes are ignored, including a strobe sampled at the edge that completes the final beat. A strobe sampled at the next edge is accepted.
- R10: A hit with invalidate = 1 clears the line's valid bit, after the write-back if the line is dirty. A dirty hit with invalidate = 0 leaves the line valid and clean. A hit to a clean line with invalidate = 0 leaves the line unchanged.
- R11: When `pre_we` is high at an edge, the line at `pre_idx` takes `pre_tag`, `pre_valid` and `pre_dirty`. At reset all lines are invalid and clean, `hit_n` and `hitm_n` are 1, and all bus outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_req | input | 1 | External master asks for the bus |
| hold_ack | output | 1 | Bus granted to the external master |
| snp_strobe | input | 1 | Snoop request, active high |
| snp_inv | input | 1 | Invalidate flag sampled with the strobe |
| snp_addr | input | 32 | Snoop address |
| hit_n | output | 1 | Snoop hit, active low |
| hitm_n | output | 1 | Snoop hit to a modified line, active low |
| bus_ads | output | 1 | Burst address strobe |
| bus_addr | output | 32 | Burst beat address |
| bus_data | output | 32 | Burst write data |
| bus_rdy_n | input | 1 | Beat ready, active low |
| bus_last | output | 1 | Final beat marker |
| bus_wr | output | 1 | Write direction during the burst |
| bus_mem | output | 1 | Memory-space cycle during the burst |
| pre_we | input | 1 | Preload write enable |
| pre_idx | input | 4 | Preload line index |
| pre_tag | input | 24 | Preload tag |
| pre_valid | input | 1 | Preload valid bit |
| pre_dirty | input | 1 | Preload dirty bit |

## Verification
The hardest case to reach from the ports is the boundary at the end of a write-back. A strobe sampled on the edge that finishes the fourth beat must be dropped, and a strobe one edge later must be taken, which needs `hold_ack` to be high again at that exact moment. The bench raises `hold_req` again partway through the burst. It places one strobe in the cycle of the final ready and the next in the cycle right after it, so the lines they target show which of the two was accepted. A sweep covers every line in four states with both invalidate values, and a follow-up snoop after each one shows the state the line was left in.

// File: rtl/snoop_pkg.sv
// Package: shared types of the snoop controller.
// Assumes: nothing beyond the importing modules' parameters.
package snoop_pkg;
    // Write-back engine phases
    typedef enum logic [1:0] {
        WB_IDLE = 2'd0,
        WB_WAIT = 2'd1,
        WB_XFER = 2'd2
    } wb_state_e;
endpackage

// File: rtl/snp_hold_sync.sv
// Module: bus hold handshake.
// Follows the hold request with a one-clock registered acknowledge, and
// keeps the acknowledge low while the block's own burst owns the bus.
// Assumes: bus_own drops in the same cycle as the final beat's ready.
module snp_hold_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic bus_own,
    output logic hold_ack
);
    // Registered acknowledge, withheld while the burst runs
    always_ff @(posedge clk) begin
        if (!rst_n) hold_ack <= 1'b0;
        else        hold_ack <= hold_req && !bus_own;
    end

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(hold_req)); // R1
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack) |-> (!$past(hold_req) || $past(bus_own))); // R1
endmodule

// File: rtl/snp_tag_store.sv
// Module: direct-mapped tag store with valid and dirty bits per line.
// Reads are combinational. The preload port writes the tag and both flags.
// The update port rewrites the flags only and takes priority.
// Assumes: preload and update are not used on the same line in one cycle.
module snp_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             pl_we,
    input  logic [IDX_W-1:0] pl_idx,
    input  logic [TAG_W-1:0] pl_tag,
    input  logic             pl_valid,
    input  logic             pl_dirty,
    input  logic             up_en,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             up_valid,
    input  logic             up_dirty
);
    logic [TAG_W-1:0] tags   [LINES];
    logic             valids [LINES];
    logic             dirtys [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // One line's tag and flags
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tags[g]   <= '0;
                valids[g] <= 1'b0;
                dirtys[g] <= 1'b0;
            end else if (up_en && up_idx == IDX_W'(g)) begin
                valids[g] <= up_valid;
                dirtys[g] <= up_dirty;
            end else if (pl_we && pl_idx == IDX_W'(g)) begin
                tags[g]   <= pl_tag;
                valids[g] <= pl_valid;
                dirtys[g] <= pl_dirty;
            end
        end
    end

    // Combinational lookup
    always_comb begin
        rd_tag   = tags[rd_idx];
        rd_valid = valids[rd_idx];
        rd_dirty = dirtys[rd_idx];
    end
endmodule

// File: rtl/snp_wb_burst.sv
// Module: write-back burst engine.
// On start it holds the line base address, waits until the external master
// has released the bus, then drives beats at base + i*BEAT_BYTES, moving on
// one beat per clock with ready sampled low.
// Assumes: start pulses only while the engine is idle.
module snp_wb_burst
    import snoop_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEATS      = 4,
    parameter int BEAT_BYTES = 4,
    localparam int BEAT_W  = $clog2(BEATS),
    localparam int OFF_W   = $clog2(BEATS * BEAT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_base,
    input  logic              hold_req,
    input  logic              hold_ack,
    input  logic              rdy_n,
    output logic              ads,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] data,
    output logic              last,
    output logic              wr,
    output logic              mem,
    output logic              busy,
    output logic              own,
    output logic              done
);
    wb_state_e         state;
    logic [BEAT_W-1:0] beat;
    logic              first;
    logic [ADDR_W-1:0] base;
    logic              xfer;

    // Phase sequencing and beat counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WB_IDLE;
            beat  <= '0;
            first <= 1'b0;
            base  <= '0;
        end else begin
            case (state)
                WB_IDLE: if (start) begin
                    base  <= start_base;
                    state <= WB_WAIT;
                end
                WB_WAIT: if (!hold_req && !hold_ack) begin
                    state <= WB_XFER;
                    beat  <= '0;
                    first <= 1'b1;
                end
                WB_XFER: begin
                    first <= 1'b0;
                    if (!rdy_n) begin
                        if (beat == BEAT_W'(BEATS - 1)) state <= WB_IDLE;
                        else                            beat  <= beat + 1'b1;
                    end
                end
                default: state <= WB_IDLE;
            endcase
        end
    end

    // Bus outputs, all quiet outside the burst
    always_comb begin
        xfer = (state == WB_XFER);
        ads  = xfer && first;
        addr = xfer ? base + ADDR_W'(beat) * ADDR_W'(BEAT_BYTES) : '0;
        data = addr;
        last = xfer && (beat == BEAT_W'(BEATS - 1));
        wr   = xfer;
        mem  = xfer;
        busy = (state != WB_IDLE);
        done = last && !rdy_n;
        own  = xfer && !done;
    end

    AST_ADS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ads |=> !ads); // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && rdy_n) |=> $stable(addr)); // R6
    AST_LAST_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> (addr[OFF_W-1:0] == OFF_W'((BEATS - 1) * BEAT_BYTES))); // R5
    AST_ADS_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ads |-> (!hold_ack && !hold_req)); // R7
endmodule

// File: rtl/snoop_ctrl.sv
// Module: snoop response controller (top).
// Takes one snoop at a time: strobe capture, tag lookup, result two clocks
// after the strobe, then a write-back burst on a dirty hit and the
// line-state update.
// Assumes: the preload port is used only while no snoop is in progress.
module snoop_ctrl
    import snoop_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINES      = 16,
    parameter int BEATS      = 4,
    parameter int BEAT_BYTES = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(BEATS * BEAT_BYTES),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_req,
    output logic              hold_ack,
    input  logic              snp_strobe,
    input  logic              snp_inv,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              hit_n,
    output logic              hitm_n,
    output logic              bus_ads,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] bus_data,
    input  logic              bus_rdy_n,
    output logic              bus_last,
    output logic              bus_wr,
    output logic              bus_mem,
    input  logic              pre_we,
    input  logic [IDX_W-1:0]  pre_idx,
    input  logic [TAG_W-1:0]  pre_tag,
    input  logic              pre_valid,
    input  logic              pre_dirty
);
    logic              s1_v, s1_inv;
    logic [ADDR_W-1:0] s1_addr;
    logic              s2_v, s2_hit, s2_dirty, s2_inv;
    logic [IDX_W-1:0]  s2_idx;
    logic [ADDR_W-1:0] s2_base;
    logic [IDX_W-1:0]  wb_idx;
    logic              wb_inv;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_valid, lk_dirty;
    logic              wb_busy, wb_own, wb_done, wb_start;
    logic              accept, busy;
    logic              up_en, up_valid, up_dirty;
    logic [IDX_W-1:0]  up_idx;

    snp_hold_sync u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_req (hold_req),
        .bus_own  (wb_own),
        .hold_ack (hold_ack)
    );

    snp_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (s1_addr[OFF_W +: IDX_W]),
        .rd_tag   (lk_tag),
        .rd_valid (lk_valid),
        .rd_dirty (lk_dirty),
        .pl_we    (pre_we),
        .pl_idx   (pre_idx),
        .pl_tag   (pre_tag),
        .pl_valid (pre_valid),
        .pl_dirty (pre_dirty),
        .up_en    (up_en),
        .up_idx   (up_idx),
        .up_valid (up_valid),
        .up_dirty (up_dirty)
    );

    snp_wb_burst #(.ADDR_W(ADDR_W), .BEATS(BEATS), .BEAT_BYTES(BEAT_BYTES)) u_wb (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (wb_start),
        .start_base (s2_base),
        .hold_req   (hold_req),
        .hold_ack   (hold_ack),
        .rdy_n      (bus_rdy_n),
        .ads        (bus_ads),
        .addr       (bus_addr),
        .data       (bus_data),
        .last       (bus_last),
        .wr         (bus_wr),
        .mem        (bus_mem),
        .busy       (wb_busy),
        .own        (wb_own),
        .done       (wb_done)
    );

    // Acceptance: bus granted and nothing in flight
    always_comb begin
        busy     = s1_v || s2_v || wb_busy;
        accept   = snp_strobe && hold_ack && !busy;
        wb_start = s2_v && s2_hit && s2_dirty;
    end

    // Line-state update: clean-hit invalidate at result time, else at burst end
    always_comb begin
        up_en    = 1'b0;
        up_idx   = s2_idx;
        up_valid = 1'b1;
        up_dirty = 1'b0;
        if (wb_done) begin
            up_en    = 1'b1;
            up_idx   = wb_idx;
            up_valid = !wb_inv;
        end else if (s2_v && s2_hit && !s2_dirty && s2_inv) begin
            up_en    = 1'b1;
            up_valid = 1'b0;
        end
    end

    // Stage 1: capture the accepted strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_inv  <= 1'b0;
            s1_addr <= '0;
        end else begin
            s1_v <= accept;
            if (accept) begin
                s1_inv  <= snp_inv;
                s1_addr <= snp_addr;
            end
        end
    end

    // Stage 2: register the lookup outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v     <= 1'b0;
            s2_hit   <= 1'b0;
            s2_dirty <= 1'b0;
            s2_inv   <= 1'b0;
            s2_idx   <= '0;
            s2_base  <= '0;
        end else begin
            s2_v <= s1_v;
            if (s1_v) begin
                s2_hit   <= lk_valid && (lk_tag == s1_addr[ADDR_W-1 -: TAG_W]);
                s2_dirty <= lk_dirty;
                s2_inv   <= s1_inv;
                s2_idx   <= s1_addr[OFF_W +: IDX_W];
                s2_base  <= {s1_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            end
        end
    end

    // Result outputs and the line held for write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_n  <= 1'b1;
            hitm_n <= 1'b1;
            wb_idx <= '0;
            wb_inv <= 1'b0;
        end else if (s2_v) begin
            hit_n  <= !s2_hit;
            hitm_n <= !(s2_hit && s2_dirty);
            wb_idx <= s2_idx;
            wb_inv <= s2_inv;
        end else if (wb_done) begin
            hit_n  <= 1'b1;
            hitm_n <= 1'b1;
        end
    end

    AST_ACCEPT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        s1_v |-> $past(hold_ack)); // R2
    AST_HITM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_v && s2_hit && s2_dirty) |=> !hitm_n); // R3
    AST_HITM_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_v && !(s2_hit && s2_dirty)) |=> hitm_n); // R4
    AST_NO_SNOOP_IN_WB: assert property (@(posedge clk) disable iff (!rst_n)
        wb_busy |-> !s1_v); // R9
    AST_HITM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_busy && !wb_done && !hitm_n) |=> !hitm_n); // R8
endmodule

// File: tb/tb_snoop_ctrl.sv
module tb_snoop_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hold_req, snp_strobe, snp_inv, bus_rdy_n;
    logic [31:0] snp_addr;
    logic        pre_we, pre_valid, pre_dirty;
    logic [3:0]  pre_idx;
    logic [23:0] pre_tag;
    logic        hold_ack, hit_n, hitm_n, bus_ads, bus_last, bus_wr, bus_mem;
    logic [31:0] bus_addr, bus_data;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_ctrl dut (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
        .snp_strobe(snp_strobe), .snp_inv(snp_inv), .snp_addr(snp_addr),
        .hit_n(hit_n), .hitm_n(hitm_n), .bus_ads(bus_ads), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_rdy_n(bus_rdy_n), .bus_last(bus_last),
        .bus_wr(bus_wr), .bus_mem(bus_mem), .pre_we(pre_we), .pre_idx(pre_idx),
        .pre_tag(pre_tag), .pre_valid(pre_valid), .pre_dirty(pre_dirty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] tag_of(input int idx);
        return 24'h5A0000 + 24'(idx * 24'h131);
    endfunction

    function automatic logic [31:0] mk_addr(input logic [23:0] t, input int idx, input int off);
        return {t, 4'(idx), 4'(off)};
    endfunction

    // R11: preload one line, one clock
    task automatic preload(input int idx, input logic [23:0] t, input logic v, input logic d);
        pre_we = 1'b1; pre_idx = 4'(idx); pre_tag = t; pre_valid = v; pre_dirty = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    // Snoop from a negedge; returns at the negedge after edge k+2 (R3)
    task automatic snoop(input logic [31:0] a, input logic inv,
                         input logic eh, input logic ehm, input string req);
        logic h0, m0;
        h0 = hit_n; m0 = hitm_n;
        snp_strobe = 1'b1; snp_addr = a; snp_inv = inv;
        @(negedge clk);
        snp_strobe = 1'b0; snp_inv = 1'b0;
        chk({req, " R3 hit_n before k+2"}, 32'(hit_n), 32'(h0));
        @(negedge clk);
        chk({req, " R3 hitm_n before k+2"}, 32'(hitm_n), 32'(m0));
        @(negedge clk);
        chk({req, " R4 hit_n"}, 32'(hit_n), 32'(!eh));
        chk({req, " R4 hitm_n"}, 32'(hitm_n), 32'(!ehm));
    endtask

    // Release the bus, run the burst with wait states; optional strobe on final ready
    task automatic run_wb(input logic [31:0] base, input logic late_stb,
                          input logic [31:0] late_addr);
        int n;
        hold_req = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bus_ads && n < 10);
        chk("R7 ads delay after hold drop", 32'(n), 32'd2);
        chk("R7 ack low at ads", 32'(hold_ack), 32'd0);
        for (int b = 0; b < 4; b++) begin
            if (b == 1) hold_req = 1'b1;
            for (int w = 0; w < (b & 1); w++) begin
                bus_rdy_n = 1'b1;
                chk("R6 addr in wait", bus_addr, base + 32'(4*b));
                @(negedge clk);
                chk("R6 addr held", bus_addr, base + 32'(4*b));
                chk("R1 ack low in burst", 32'(hold_ack), 32'd0);
            end
            bus_rdy_n = 1'b0;
            if (b == 3 && late_stb) begin
                snp_strobe = 1'b1; snp_addr = late_addr; snp_inv = 1'b1;
            end
            chk("R5 beat addr", bus_addr, base + 32'(4*b));
            chk("R5 beat data", bus_data, base + 32'(4*b));
            chk("R5 last", 32'(bus_last), 32'(b == 3));
            chk("R6 ads", 32'(bus_ads), 32'(b == 0));
            chk("R6 wr/mem", 32'({bus_wr, bus_mem}), 32'd3);
            chk("R8 hitm_n low in burst", 32'(hitm_n), 32'd0);
            @(negedge clk);
        end
        bus_rdy_n = 1'b1;
        snp_strobe = 1'b0; snp_inv = 1'b0;
        chk("R8 hitm_n released", 32'(hitm_n), 32'd1);
        chk("R8 hit_n released", 32'(hit_n), 32'd1);
        chk("R1 ack back at final edge", 32'(hold_ack), 32'd1);
        chk("R5 bus quiet", 32'({bus_ads, bus_last, bus_wr}), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * WDOG_CYCLES);
        fails++;
        $display("FAIL WDOG actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] a, a6, a7;
        logic [23:0] t;
        logic eh, ehm;
        logic h0, m0;
        int ads_seen;
        rst_n = 1'b0; hold_req = 1'b0; snp_strobe = 1'b0; snp_inv = 1'b0;
        snp_addr = '0; bus_rdy_n = 1'b1; pre_we = 1'b0; pre_idx = '0;
        pre_tag = '0; pre_valid = 1'b0; pre_dirty = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 reset hit_n/hitm_n", 32'({hit_n, hitm_n}), 32'd3);
        chk("R11 reset bus", 32'({bus_ads, bus_last, bus_wr, bus_mem}), 32'd0);
        chk("R11 reset addr", bus_addr, 32'd0);
        chk("R1 reset ack", 32'(hold_ack), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        hold_req = 1'b1;
        @(negedge clk);
        chk("R1 ack one clock after req", 32'(hold_ack), 32'd1);

        // Sweep: every line, four states, both invalidate values (R4, R10)
        for (int idx = 0; idx < 16; idx++) begin
            for (int k = 0; k < 4; k++) begin
                for (int inv = 0; inv < 2; inv++) begin
                    t = tag_of(idx);
                    preload(idx, (k == 3) ? (t ^ 24'h1) : t, k != 0, k >= 2);
                    a = mk_addr(t, idx, (idx * 5 + k * 3 + inv) & 15);
                    eh  = (k == 1) || (k == 2);
                    ehm = (k == 2);
                    snoop(a, 1'(inv), eh, ehm, "R4 sweep");
                    if (ehm) run_wb({a[31:4], 4'h0}, 1'b0, 32'd0);
                    snoop(a, 1'b0, eh && (inv == 0), 1'b0, "R10 follow-up");
                end
            end
        end

        // R2: strobe without acknowledge is ignored
        preload(3, tag_of(3), 1'b1, 1'b1);
        a = mk_addr(tag_of(3), 3, 8);
        snoop(mk_addr(24'h0, 0, 0), 1'b0, 1'b0, 1'b0, "R2 prep miss");
        hold_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 ack drops", 32'(hold_ack), 32'd0);
        h0 = hit_n; m0 = hitm_n;
        snp_strobe = 1'b1; snp_addr = a; snp_inv = 1'b1;
        @(negedge clk);
        snp_strobe = 1'b0; snp_inv = 1'b0;
        ads_seen = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (bus_ads) ads_seen++;
        end
        chk("R2 no burst when not held", 32'(ads_seen), 32'd0);
        chk("R2 hit_n unchanged", 32'(hit_n), 32'(h0));
        chk("R2 hitm_n unchanged", 32'(hitm_n), 32'(m0));
        hold_req = 1'b1;
        @(negedge clk);
        snoop(a, 1'b0, 1'b1, 1'b1, "R2 line still dirty");
        run_wb({a[31:4], 4'h0}, 1'b0, 32'd0);

        // R9: strobes ignored while busy, accepted right after the final beat
        a  = mk_addr(tag_of(5), 5, 4);
        a6 = mk_addr(tag_of(6), 6, 12);
        a7 = mk_addr(tag_of(7), 7, 0);
        preload(5, tag_of(5), 1'b1, 1'b1);
        preload(6, tag_of(6), 1'b1, 1'b1);
        preload(7, tag_of(7), 1'b1, 1'b0);
        snoop(a, 1'b0, 1'b1, 1'b1, "R9 first dirty hit");
        snp_strobe = 1'b1; snp_addr = a6; snp_inv = 1'b1;
        @(negedge clk);
        snp_strobe = 1'b0; snp_inv = 1'b0;
        chk("R9 busy strobe no effect", 32'(hitm_n), 32'd0);
        run_wb({a[31:4], 4'h0}, 1'b1, a7);
        snoop(a6, 1'b0, 1'b1, 1'b1, "R9 accepted after final beat");
        run_wb({a6[31:4], 4'h0}, 1'b0, 32'd0);
        snoop(a7, 1'b0, 1'b1, 1'b0, "R9 final-edge strobe ignored");
        snoop(a, 1'b0, 1'b1, 1'b0, "R10 read dirty hit left clean");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule